// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block takes a wide bus of GPIO pad inputs and routes any eight of them onto eight interrupt output lines for a downstream interrupt controller. Each output line has its own programmable pad index, an optional polarity inversion, a choice between level and single-edge sensing, and an optional stability filter. The downstream controller can therefore treat every line as active-high, even when the source is active-low or signals on a falling edge.

Each selected pad goes through a two-flop synchroniser. The inversion is applied next, then the optional filter. The result drives the output either as a level or as a one-cycle pulse on a rising transition. Software configures the block through a 32-bit register port. The port has write and read strobes and a 2-bit word address, and read data is registered.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset every configuration field is zero, `irq_o` is all zero, and all four words read back as zero.
- R2: Word 0 holds per-channel edge-mode enables in bits [7:0] (bit n for channel n; 1 = edge, 0 = level) and per-channel invert enables in bits [23:16] (bit 16+n). Its other bits read as zero. Word 1 holds the pad indices of channels 0 to 3, and word 2 those of channels 4 to 7, each in bits [(n%4)*8 +: 8]. Word 3 holds the 4-bit filter setting of channel n in bits [n*4 +: 4]. Read data appears on `reg_rdata_o` in the cycle after the read strobe.
- R3: Channel n samples the pad named by its index. A new index is used from the clock cycle after the write. An index at or above the pad count feeds a constant 0.
- R4: In level mode with the filter off, a pad change set up before clock edge k appears on `irq_o` after edge k+2.
- R5: When a channel's invert bit is set, the output is high while the selected pad is low, and low while the pad is high.
- R6: In edge mode a channel emits a one-cycle high pulse when its inverted, synchronised input rises from 0 to 1, and never on the opposite transition.
- R7: A filter setting of 0 bypasses the filter. A nonzero setting v changes the filtered level only after the input has differed from it for v*8 consecutive cycles. A shorter glitch is dropped, and a qualified change reaches `irq_o` v*8 cycles later than it would unfiltered.
- R8: Channels are independent: configuring or stimulating one channel leaves the other outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 8 | Active-high interrupt lines, one per channel |

## Verification
The bench measures the exact latency from a pad change to the output. A design with one synchroniser stage too few or too many is one cycle early or late. A pad-index rewrite that took hold late would keep the old pad's value a cycle too long. Edge mode is checked for exactly one pulse in each direction of the inverted input; a design that sensed both edges, or held the output as a level, would show extra or longer pulses. The filter is fed a glitch shorter than its window and then a sustained change. A counter that failed to restart on a glitch, or was off by one, would pass the glitch or release the change a cycle early or late.

// File: rtl/gpio_irq_mux_pkg.sv
package gpio_irq_mux_pkg;
  localparam int NUM_CH  = 8;
  localparam int SEL_W   = 8;
  localparam int FILT_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int INV_LSB = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FILT   = 2'd3;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    {{(INV_LSB-NUM_CH){1'b0}}, {NUM_CH{1'b1}}, {(INV_LSB-NUM_CH){1'b0}}, {NUM_CH{1'b1}}};

  typedef struct packed {
    logic              edge_mode;
    logic              invert;
    logic [SEL_W-1:0]  sel;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;
endpackage

// File: rtl/gpio_irq_mux_regs.sv
module gpio_irq_mux_regs
  import gpio_irq_mux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output chan_cfg_t         cfg_o [NUM_CH]
);
  localparam int FLD_PER_WORD = DATA_W / SEL_W;

  logic [NUM_CH-1:0] edge_q, inv_q;
  logic [DATA_W-1:0] sel_lo_q, sel_hi_q, filt_q, rdata_q, rd_mux, ctrl_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q   <= '0;
      inv_q    <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      filt_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          edge_q <= wdata_i[NUM_CH-1:0];
          inv_q  <= wdata_i[INV_LSB +: NUM_CH];
        end
        ADDR_SEL_LO: sel_lo_q <= wdata_i;
        ADDR_SEL_HI: sel_hi_q <= wdata_i;
        default:     filt_q   <= wdata_i;
      endcase
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NUM_CH-1:0]        = edge_q;
    ctrl_word[INV_LSB +: NUM_CH] = inv_q;
    unique case (addr_i)
      ADDR_CTRL:   rd_mux = ctrl_word;
      ADDR_SEL_LO: rd_mux = sel_lo_q;
      ADDR_SEL_HI: rd_mux = sel_hi_q;
      default:     rd_mux = filt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
    assign cfg_o[ch].edge_mode = edge_q[ch];
    assign cfg_o[ch].invert    = inv_q[ch];
    assign cfg_o[ch].filt      = filt_q[ch*FILT_W +: FILT_W];
    if (ch < FLD_PER_WORD) begin : g_lo
      assign cfg_o[ch].sel = sel_lo_q[(ch % FLD_PER_WORD)*SEL_W +: SEL_W];
    end else begin : g_hi
      assign cfg_o[ch].sel = sel_hi_q[(ch % FLD_PER_WORD)*SEL_W +: SEL_W];
    end
  end

  // R2: unused control bits never appear on a control-word read
  a_r2_ctrl_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == ADDR_CTRL) |-> ((rdata_o & ~CTRL_MASK) == '0));
endmodule

// File: rtl/gpio_irq_mux_filter.sv
module gpio_irq_mux_filter #(
  parameter int FILT_W    = 4,
  parameter int UNIT_LOG2 = 3,
  localparam int CNT_W    = FILT_W + UNIT_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic [FILT_W-1:0] sel_i,
  output logic              out_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
  logic             lvl_q;

  assign limit   = {sel_i, {UNIT_LOG2{1'b0}}};
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (sel_i == '0) begin
      cnt_q <= '0;
      lvl_q <= in_i;
    end else if (in_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_inc >= limit) begin
      cnt_q <= '0;
      lvl_q <= in_i;
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  assign out_o = (sel_i == '0) ? in_i : lvl_q;

  // R7: counter stays inside the window while the setting is steady
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != '0 && $stable(sel_i)) |-> (cnt_q < limit));

  // R7: filtered level holds when the input already agreed with it
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != '0 && $past(sel_i) != '0 && $past(in_i) == $past(lvl_q)) |-> $stable(lvl_q));
endmodule

// File: rtl/gpio_irq_mux_chan.sv
module gpio_irq_mux_chan
  import gpio_irq_mux_pkg::*;
#(
  parameter int NUM_PADS  = 134,
  parameter int UNIT_LOG2 = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  chan_cfg_t           cfg_i,
  output logic                irq_o
);
  localparam int PAD_SPACE = 2**SEL_W;

  logic [PAD_SPACE-1:0] pad_ext;
  logic [1:0]           sync_q;
  logic                 pad_sel, inv_lvl, filt_lvl, prev_q, irq_q;

  // out-of-range indices land on zero padding
  always_comb begin
    pad_ext = '0;
    pad_ext[NUM_PADS-1:0] = pad_i;
  end
  assign pad_sel = pad_ext[cfg_i.sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], pad_sel};
  end

  assign inv_lvl = sync_q[1] ^ cfg_i.invert;

  gpio_irq_mux_filter #(
    .FILT_W   (FILT_W),
    .UNIT_LOG2(UNIT_LOG2)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (inv_lvl),
    .sel_i (cfg_i.filt),
    .out_o (filt_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= filt_lvl;
      irq_q  <= cfg_i.edge_mode ? (filt_lvl & ~prev_q) : filt_lvl;
    end
  end
  assign irq_o = irq_q;

  // R6: an edge-mode pulse lasts exactly one cycle
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.edge_mode && irq_q) |=> !(irq_q && cfg_i.edge_mode));

  // R4: level mode output tracks the filtered level one cycle later
  a_r4_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_i.edge_mode) |-> (irq_q == $past(filt_lvl)));

  // R3: out-of-range index feeds zero into the synchroniser
  a_r3_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_i.sel) >= NUM_PADS) |=> !sync_q[0]);
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_mux_pkg::*;
#(
  parameter int NUM_PADS  = 134,
  parameter int UNIT_LOG2 = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [7:0]          irq_o
);
  chan_cfg_t cfg [NUM_CH];

  gpio_irq_mux_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    gpio_irq_mux_chan #(
      .NUM_PADS (NUM_PADS),
      .UNIT_LOG2(UNIT_LOG2)
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pad_i (pad_i),
      .cfg_i (cfg[ch]),
      .irq_o (irq_o[ch])
    );
  end
endmodule

// File: tb/gpio_irq_mux_bench.sv
`timescale 1ns/1ps
module gpio_irq_mux_bench;
  localparam int NUM_PADS = 134;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NUM_PADS-1:0] pads = '0;
  logic                wr = 1'b0, rd = 1'b0;
  logic [1:0]          addr = '0;
  logic [31:0]         wdata = '0, rdata, rv;
  logic [7:0]          irq;

  int n_tests = 0, n_fail = 0;
  logic [2:0] e_ch;
  logic [7:0] e_idx;
  logic       e_inv, e_val, e_exp;
  logic       flag;

  always #4 clk = ~clk;

  gpio_irq_mux #(.NUM_PADS(NUM_PADS)) u_gpio_irq_mux (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pads),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {ch[13:11], pad index[10:3], invert[2], pad value[1], expected irq[0]}
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 8'd5,   1'b0, 1'b1, 1'b1},
    {3'd1, 8'd133, 1'b0, 1'b1, 1'b1},
    {3'd2, 8'd64,  1'b1, 1'b0, 1'b1},
    {3'd3, 8'd64,  1'b1, 1'b1, 1'b0},
    {3'd4, 8'd1,   1'b0, 1'b0, 1'b0},
    {3'd5, 8'd200, 1'b1, 1'b0, 1'b1},
    {3'd6, 8'd100, 1'b0, 1'b1, 1'b1},
    {3'd7, 8'd7,   1'b1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick(1);
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    check(irq == 8'h00, "R1 irq after reset", {24'b0, irq}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), rv);
      check(rv == 32'h0, "R1 readback after reset", rv, 32'h0);
    end

    // R2 readback and masking
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, rv);
    check(rv == 32'h00FF_00FF, "R2 control word mask", rv, 32'h00FF_00FF);
    wr_reg(2'd3, 32'h8765_4321);
    rd_reg(2'd3, rv);
    check(rv == 32'h8765_4321, "R2 filter word", rv, 32'h8765_4321);
    wr_reg(2'd2, 32'hA5A5_A5A5);
    rd_reg(2'd2, rv);
    check(rv == 32'hA5A5_A5A5, "R2 select word high", rv, 32'hA5A5_A5A5);
    wr_reg(2'd0, 0); wr_reg(2'd1, 0); wr_reg(2'd2, 0); wr_reg(2'd3, 0);
    tick(12);

    // R4 latency: ch0 on pad 3
    wr_reg(2'd1, 32'd3);
    tick(4);
    pads[3] = 1'b1;
    tick(2);
    check(irq == 8'h00, "R4 not yet after two edges", {24'b0, irq}, 32'h0);
    tick(1);
    check(irq == 8'h01, "R4 visible after third edge", {24'b0, irq}, 32'h1);

    // R3 new select used from the next cycle
    pads[9] = 1'b0;
    wr_reg(2'd1, 32'd9);
    tick(2);
    check(irq == 8'h01, "R3 old pad still in pipeline", {24'b0, irq}, 32'h1);
    tick(1);
    check(irq == 8'h00, "R3 new pad reached output", {24'b0, irq}, 32'h0);

    // table: R3 R5 R8 level mode
    for (int i = 0; i < 8; i++) begin
      {e_ch, e_idx, e_inv, e_val, e_exp} = VEC[i];
      pads = '0;
      wr_reg(2'd0, 0); wr_reg(2'd1, 0); wr_reg(2'd2, 0);
      tick(4);
      wr_reg((e_ch < 3'd4) ? 2'd1 : 2'd2, 32'(e_idx) << (8 * (e_ch % 4)));
      wr_reg(2'd0, 32'(e_inv) << (16 + e_ch));
      if (int'(e_idx) < NUM_PADS) pads[e_idx] = e_val;
      tick(4);
      check(irq == (8'(e_exp) << e_ch), "R3 R5 R8 table vector",
            {24'b0, irq}, {24'b0, 8'(e_exp) << e_ch});
    end

    // R6 edge mode on ch1, pad 10
    pads = '0;
    wr_reg(2'd0, 0); wr_reg(2'd2, 0);
    wr_reg(2'd1, 32'd10 << 8);
    wr_reg(2'd0, 32'h2);
    tick(4);
    pads[10] = 1'b1;
    tick(2);
    check(irq == 8'h00, "R6 no pulse before latency", {24'b0, irq}, 32'h0);
    tick(1);
    check(irq == 8'h02, "R6 rising pulse", {24'b0, irq}, 32'h2);
    tick(1);
    check(irq == 8'h00, "R6 pulse one cycle wide", {24'b0, irq}, 32'h0);
    pads[10] = 1'b0;
    flag = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      if (irq != 8'h00) flag = 1'b0;
    end
    check(flag, "R6 no pulse on falling input", {31'b0, flag}, 32'h1);

    // R6 with R5 invert: falling pad gives the pulse
    wr_reg(2'd0, 32'h0002_0002);
    tick(6);
    pads[10] = 1'b1;
    flag = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      if (irq != 8'h00) flag = 1'b0;
    end
    check(flag, "R6 inverted no pulse on rising pad", {31'b0, flag}, 32'h1);
    pads[10] = 1'b0;
    tick(3);
    check(irq == 8'h02, "R6 inverted pulse on falling pad", {24'b0, irq}, 32'h2);
    tick(1);
    check(irq == 8'h00, "R6 inverted pulse ends", {24'b0, irq}, 32'h0);

    // R7 filter on ch2, pad 20, setting 1 (8 cycles)
    pads = '0;
    wr_reg(2'd0, 0);
    wr_reg(2'd1, 32'd20 << 16);
    wr_reg(2'd3, 32'h1 << 8);
    tick(4);
    pads[20] = 1'b1;
    tick(5);
    pads[20] = 1'b0;
    flag = 1'b1;
    for (int k = 0; k < 15; k++) begin
      tick(1);
      if (irq != 8'h00) flag = 1'b0;
    end
    check(flag, "R7 short glitch dropped", {31'b0, flag}, 32'h1);
    pads[20] = 1'b1;
    tick(10);
    check(irq == 8'h00, "R7 held back inside window", {24'b0, irq}, 32'h0);
    tick(1);
    check(irq == 8'h04, "R7 released after window", {24'b0, irq}, 32'h4);
    pads[20] = 1'b0;
    tick(10);
    check(irq == 8'h04, "R7 fall held back", {24'b0, irq}, 32'h4);
    tick(1);
    check(irq == 8'h00, "R7 fall released", {24'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule